// File: doc/BRIEF.md
# Aggregated Frequency Quota Power Cap Controller

This block closes the outer loop of a chip power cap. Once per control period it receives one sample: the measured power of the whole chip and the power budget in force. It turns the gap between them into a correction of a single aggregated frequency quota. The quota is the sum of the normalized frequency levels of all cores, where 1.0 stands for one core at its peak level. A downstream partitioner divides the quota among the cores.

The correction is a pure integral law. The new quota is the previous quota plus the power error times a fixed reciprocal gain, and the product is rounded toward zero. The gain is fixed at design time as the inverse of a worst-case power-per-quota slope. Before it is published, the result is clamped between the lowest legal quota (lowest normalized level times core count) and the core count (every core at peak). A flag marks each period in which the clamp acted.

Samples arrive on a valid/ready stream, and results leave on another valid/ready stream. The result register holds one entry. A sample is accepted only when that register is empty or is being emptied in the same cycle. While the partitioner holds off its ready, the published quota and flag stay frozen and the input ready is low, so no sample is consumed and none is lost. The core count and the lowest level are plain configuration pins, read in the cycle a sample is accepted.

Top module: `pcap_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `quota_valid` is low and `in_ready` is high. The internal quota starts at `core_count` x 256, so a first sample with zero error yields exactly that value.
- R2: For an accepted sample, error = `budget` - `power`, as a signed value. When no clamp applies, the new `quota` is the previous quota plus trunc((error x RECIP) / 2^RFRAC). With the defaults (RECIP = 64, RFRAC = 8) the increment is error/4 in quota LSBs.
- R3: The scaled correction is rounded toward zero for both signs. With the defaults, an error of +2, -1 or -3 changes nothing, and an error of -5 lowers the quota by exactly 1 LSB.
- R4: If the corrected value exceeds `core_count` x 256, the output is that upper limit and `quota_sat` is 1.
- R5: If the corrected value is below `min_level` x `core_count`, the output is that lower limit and `quota_sat` is 1. `min_level` is unsigned with 8 fractional bits.
- R6: `quota_sat` is 0 whenever the corrected value lies inside the limits, including a value exactly equal to a limit.
- R7: `quota` is unsigned with 8 fractional bits, so 256 means one core at peak. A sample accepted in cycle k (`in_valid` and `in_ready` both high) gives `quota_valid` = 1 with the new result in cycle k+1. The quota changes only on accepted samples.
- R8: While `quota_valid` is 1 and `quota_ready` is 0, `in_ready` is 0, and `quota` and `quota_sat` hold their values. Samples offered during this time are not consumed. After the consumer accepts the result, `quota_valid` falls unless a new sample was accepted in the same cycle.
- R9: The limits use the `core_count` and `min_level` present in the cycle a sample is accepted. A change of these pins takes effect on the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample (period strobe) offered |
| in_ready | output | 1 | Sample can be accepted |
| budget | input | PWR_W | Chip power budget |
| power | input | PWR_W | Measured chip power for the period |
| core_count | input | CORE_W | Number of cores, at least 1 |
| min_level | input | FRAC | Lowest normalized level, 8 fractional bits |
| quota_valid | output | 1 | Result available |
| quota_ready | input | 1 | Partitioner takes the result |
| quota | output | CORE_W+FRAC | Aggregated frequency quota, 8 fractional bits |
| quota_sat | output | 1 | Clamp acted on this result |

## Verification
The quota is an integrator. Any wrong internal value shows up at the ports on the very next accepted sample, and it persists in every later result until a clamp absorbs it. A zero-error sample therefore exposes the held state directly, one cycle after acceptance. The rounding direction is visible within one sample through small negative errors. Errors in handshake state appear in the same cycle as a mismatch between `in_ready` and a frozen `quota`.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_HIGH = 2'd1,
    CL_LOW  = 2'd2
  } clamp_kind_e;
endpackage

// File: rtl/pcap_err_scale.sv
module pcap_err_scale #(
  parameter int PWR_W   = 12,
  parameter int RECIP_W = 8,
  parameter int RECIP   = 64,
  parameter int RFRAC   = 8,
  localparam int ERR_W  = PWR_W + 1,
  localparam int PROD_W = ERR_W + RECIP_W + 1,
  localparam int DEL_W  = PROD_W - RFRAC
) (
  input  logic [PWR_W-1:0]        budget_i,
  input  logic [PWR_W-1:0]        power_i,
  output logic signed [DEL_W-1:0] delta_o
);
  logic signed [ERR_W-1:0]  err;
  logic signed [PROD_W-1:0] err_x, rcp_x, prod, adj;

  always_comb begin
    err   = $signed({1'b0, budget_i}) - $signed({1'b0, power_i});
    err_x = PROD_W'(err);
    rcp_x = PROD_W'(RECIP);
    prod  = err_x * rcp_x;
    // bias negative products so the shift truncates toward zero
    adj   = prod + (prod[PROD_W-1] ? PROD_W'((1 << RFRAC) - 1) : PROD_W'(0));
    delta_o = DEL_W'(adj >>> RFRAC);
  end

  always_comb begin
    if (err == '0) AST_ZERO_ERR_ZERO_STEP: assert (delta_o == '0); // R2
    if (err > 0)   AST_POS_ERR_NO_DROP: assert (!delta_o[DEL_W-1]); // R3
    if (err < 0)   AST_NEG_ERR_NO_RISE: assert (delta_o[DEL_W-1] || delta_o == '0); // R3
  end
endmodule

// File: rtl/pcap_clamp.sv
module pcap_clamp
  import pcap_pkg::*;
#(
  parameter int CORE_W = 8,
  parameter int FRAC   = 8,
  parameter int DEL_W  = 14,
  localparam int QW    = CORE_W + FRAC,
  localparam int SUM_W = ((QW > DEL_W) ? QW : DEL_W) + 2
) (
  input  logic [QW-1:0]           cur_i,
  input  logic signed [DEL_W-1:0] delta_i,
  input  logic [CORE_W-1:0]       core_count_i,
  input  logic [FRAC-1:0]         min_level_i,
  output logic [QW-1:0]           nxt_o,
  output clamp_kind_e             kind_o
);
  logic [QW-1:0]           hi, lo;
  logic signed [SUM_W-1:0] sum, hi_s, lo_s;

  always_comb begin
    hi   = {core_count_i, FRAC'(0)};
    lo   = QW'(core_count_i * min_level_i);
    sum  = $signed(SUM_W'(cur_i)) + SUM_W'(delta_i);
    hi_s = $signed(SUM_W'(hi));
    lo_s = $signed(SUM_W'(lo));
    if (sum > hi_s) begin
      nxt_o  = hi;
      kind_o = CL_HIGH;
    end else if (sum < lo_s) begin
      nxt_o  = lo;
      kind_o = CL_LOW;
    end else begin
      nxt_o  = QW'(sum);
      kind_o = CL_NONE;
    end
  end

  always_comb begin
    AST_RESULT_LE_HI: assert (nxt_o <= hi); // R4
    if (kind_o == CL_LOW) AST_LOW_SAT_AT_LO: assert (nxt_o == lo); // R5
  end
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int PWR_W   = 12,
  parameter int CORE_W  = 8,
  parameter int FRAC    = 8,
  parameter int RECIP_W = 8,
  parameter int RECIP   = 64,
  parameter int RFRAC   = 8,
  localparam int QW     = CORE_W + FRAC,
  localparam int DEL_W  = PWR_W + 2 + RECIP_W - RFRAC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PWR_W-1:0]  budget,
  input  logic [PWR_W-1:0]  power,
  input  logic [CORE_W-1:0] core_count,
  input  logic [FRAC-1:0]   min_level,
  output logic              quota_valid,
  input  logic              quota_ready,
  output logic [QW-1:0]     quota,
  output logic              quota_sat
);
  logic [QW-1:0]           quota_r, nxt;
  logic                    vld_r, sat_r, take;
  logic signed [DEL_W-1:0] delta;
  clamp_kind_e             kind;

  pcap_err_scale #(
    .PWR_W(PWR_W), .RECIP_W(RECIP_W), .RECIP(RECIP), .RFRAC(RFRAC)
  ) u_scale (
    .budget_i(budget), .power_i(power), .delta_o(delta)
  );

  pcap_clamp #(
    .CORE_W(CORE_W), .FRAC(FRAC), .DEL_W(DEL_W)
  ) u_clamp (
    .cur_i(quota_r), .delta_i(delta), .core_count_i(core_count),
    .min_level_i(min_level), .nxt_o(nxt), .kind_o(kind)
  );

  assign in_ready    = !vld_r || quota_ready;
  assign take        = in_valid && in_ready;
  assign quota_valid = vld_r;
  assign quota       = quota_r;
  assign quota_sat   = sat_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      quota_r <= {core_count, FRAC'(0)};
      vld_r   <= 1'b0;
      sat_r   <= 1'b0;
    end else if (take) begin
      quota_r <= nxt;
      sat_r   <= (kind != CL_NONE);
      vld_r   <= 1'b1;
    end else if (quota_ready) begin
      vld_r   <= 1'b0;
    end
  end

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> quota_valid); // R7
  AST_IDLE_HOLDS_QUOTA: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(quota)); // R7
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (quota_valid && !quota_ready) |=> (quota_valid && $stable(quota) && $stable(quota_sat))); // R8
  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (quota_valid && !quota_ready) |-> !in_ready); // R8
endmodule

// File: tb/sim_pcap_ctrl.sv
module sim_pcap_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, quota_ready = 1'b1;
  logic [11:0] budget = '0, power = '0;
  logic [7:0]  core_count = 8'd8, min_level = 8'd64;
  logic        in_ready, quota_valid, quota_sat;
  logic [15:0] quota;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pcap_ctrl u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .budget(budget), .power(power), .core_count(core_count),
    .min_level(min_level), .quota_valid(quota_valid),
    .quota_ready(quota_ready), .quota(quota), .quota_sat(quota_sat)
  );

  // {budget, power, core_count, min_level, expected quota, expected sat}
  localparam logic [56:0] VEC [12] = '{
    {12'd1000, 12'd1400, 8'd8, 8'd64,  16'd1948, 1'b0},
    {12'd1000, 12'd1001, 8'd8, 8'd64,  16'd1948, 1'b0},
    {12'd1000, 12'd998,  8'd8, 8'd64,  16'd1948, 1'b0},
    {12'd1000, 12'd1003, 8'd8, 8'd64,  16'd1948, 1'b0},
    {12'd1000, 12'd1005, 8'd8, 8'd64,  16'd1947, 1'b0},
    {12'd2000, 12'd1000, 8'd8, 8'd64,  16'd2048, 1'b1},
    {12'd0,    12'd4000, 8'd8, 8'd64,  16'd1048, 1'b0},
    {12'd0,    12'd4000, 8'd8, 8'd64,  16'd512,  1'b1},
    {12'd1000, 12'd1000, 8'd8, 8'd64,  16'd512,  1'b0},
    {12'd3000, 12'd1000, 8'd4, 8'd128, 16'd1012, 1'b0},
    {12'd1200, 12'd1000, 8'd4, 8'd128, 16'd1024, 1'b1},
    {12'd0,    12'd1000, 8'd4, 8'd200, 16'd800,  1'b1}
  };
  localparam string TAG [12] = '{"R2", "R3", "R3", "R3", "R3", "R4",
                                 "R2", "R5", "R6", "R9", "R4", "R5"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] b, input logic [11:0] p,
                      input logic [7:0] c, input logic [7:0] m);
    @(negedge clk);
    budget = b; power = p; core_count = c; min_level = m;
    in_valid = 1'b1; quota_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(quota_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 32'(quota_valid), 0);
    check("R1 ready after reset", 32'(in_ready), 1);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][56:45], VEC[i][44:33], VEC[i][32:25], VEC[i][24:17]);
      check({TAG[i], " valid"}, 32'(quota_valid), 1);
      check({TAG[i], " quota"}, 32'(quota), 32'(VEC[i][16:1]));
      check({TAG[i], " sat"}, 32'(quota_sat), 32'(VEC[i][0]));
    end

    // R8: stall the consumer with a sample pending (quota now 800)
    step(12'd1000, 12'd1000, 8'd4, 8'd200);
    quota_ready = 1'b0;
    budget = 12'd3000; power = 12'd0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 in_ready low", 32'(in_ready), 0);
      check("R8 quota held", 32'(quota), 800);
      check("R8 valid held", 32'(quota_valid), 1);
    end
    in_valid = 1'b0; quota_ready = 1'b1;
    @(negedge clk);
    check("R8 valid falls", 32'(quota_valid), 0);
    step(12'd500, 12'd500, 8'd4, 8'd200);
    check("R8 stalled sample not consumed", 32'(quota), 800);

    // R1: reset again with six cores, zero-error sample shows initial quota
    @(negedge clk);
    rst = 1'b1; core_count = 8'd6;
    repeat (2) @(negedge clk);
    check("R1 valid cleared", 32'(quota_valid), 0);
    rst = 1'b0;
    step(12'd700, 12'd700, 8'd6, 8'd64);
    check("R1 initial quota", 32'(quota), 1536);
    check("R6 no sat at top", 32'(quota_sat), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule